// File: doc/BRIEF.md
# Three-Format Integer Instruction Decoder

This block turns one 32-bit instruction word into everything the execute stage of a small integer core needs. It splits out the source register indices, picks a destination register, and chooses the ALU operation and the ALU's second operand. It also drives the memory read and write strobes, the branch condition and the jump kind, and forms a 32-bit immediate from the instruction's constant field. Encodings outside the supported set raise an illegal flag and cancel every side effect.

The decode logic itself is purely combinational. Its whole result is captured in one output register, so every output is valid one clock after the instruction word is presented. Writes that target register index 0 are dropped at decode time, which keeps that register reading zero without any special case in the register file.

Top module: `mdec_top`

## Requirements
- R1: `rs_o` always equals instruction bits [25:21] and `rt_o` always equals bits [20:16], whatever the opcode.
- R2: With opcode 000000, funct 100000 gives ALU op 0 (add), funct 100010 gives ALU op 1 (subtract) and funct 101010 gives ALU op 2 (signed set-less-than). Each of them writes register rd (bits [15:11]) with `dst_sel_o` = 0 and takes the ALU operand from a register.
- R3: Opcode 100011 (load word) asserts `mem_rd_o` and writes rt with `dst_sel_o` = 1. Opcode 101011 (store word) asserts `mem_wr_o` and writes no register. Both use ALU op 0, an immediate operand and a sign-extended 16-bit immediate.
- R4: Opcode 001000 (add immediate) uses ALU op 0 and writes rt with `dst_sel_o` = 1. Its immediate is bits [15:0] sign-extended to 32 bits.
- R5: Opcode 001101 (or immediate) uses ALU op 3 and writes rt. Its immediate is bits [15:0] zero-extended.
- R6: Opcode 001111 (load upper) uses ALU op 4 and writes rt. Its immediate carries bits [15:0] in positions [31:16] and zeros in [15:0].
- R7: Opcode 000100 gives `branch_o` = 1 (equal) and opcode 000101 gives `branch_o` = 2 (not equal). Both use ALU op 1 and write no register. Their immediate is the sign-extended offset shifted left by two.
- R8: Opcode 000010 gives `jump_o` = 1, with immediate {4'b0, bits[25:0], 2'b00}. Opcode 000011 does the same and also asserts `link_o`, writes register 31 and gives `dst_sel_o` = 2.
- R9: With opcode 000000, funct 001000 gives `jump_o` = 2 (target from rs) and writes no register.
- R10: Any other opcode, or any other funct under opcode 000000, asserts `illegal_o`. All other outputs except `rs_o` and `rt_o` are then zero.
- R11: A register write whose destination index would be 0 is dropped: `reg_we_o` = 0 and `dst_o` = 0. `dst_o` is also 0 whenever no write is requested.
- R12: All outputs are registered and reflect the instruction sampled at the previous rising clock edge. An active-low asynchronous reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| rs_o | output | 5 | First source register index |
| rt_o | output | 5 | Second source register index |
| dst_o | output | 5 | Destination register index, 0 when no write |
| dst_sel_o | output | 2 | Destination source: 0 rd, 1 rt, 2 link register |
| reg_we_o | output | 1 | Register write enable |
| alu_op_o | output | 3 | 0 add, 1 sub, 2 slt, 3 or, 4 load-upper pass |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| mem_rd_o | output | 1 | Memory read request |
| mem_wr_o | output | 1 | Memory write request |
| branch_o | output | 2 | 0 none, 1 on equal, 2 on not equal |
| jump_o | output | 2 | 0 none, 1 to immediate target, 2 to rs |
| link_o | output | 1 | Return address goes to register 31 |
| illegal_o | output | 1 | Unsupported encoding |
| imm_o | output | 32 | Extended immediate |

## Verification
Every output is due exactly one rising edge after the instruction is applied. The driver changes `instr_i` on a falling edge and queues the expected result. The monitor pops one queued item a quarter period after each following rising edge, so each comparison targets the registered result of that single instruction. Back-to-back instructions with no idle cycles confirm that no result lags or leads by a cycle. A check made while reset is held confirms the cleared state.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

    parameter int XLEN     = 32;
    parameter int RIDX_W   = 5;
    parameter int IMM_W    = 16;
    parameter int TGT_W    = 26;
    parameter int OP_W     = 6;
    parameter int FN_W     = 6;
    parameter int LINK_REG = 31;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OP_J     = 6'b000010;
    localparam logic [OP_W-1:0] OP_JAL   = 6'b000011;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_BNE   = 6'b000101;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OP_LUI   = 6'b001111;
    localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OP_SW    = 6'b101011;

    localparam logic [FN_W-1:0] FN_ADD   = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB   = 6'b100010;
    localparam logic [FN_W-1:0] FN_SLT   = 6'b101010;
    localparam logic [FN_W-1:0] FN_JR    = 6'b001000;

    typedef enum logic [2:0] {
        ALU_ADD = 3'd0,
        ALU_SUB = 3'd1,
        ALU_SLT = 3'd2,
        ALU_OR  = 3'd3,
        ALU_LUI = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_e;

    typedef enum logic [1:0] {
        JMP_NONE = 2'd0,
        JMP_IMM  = 2'd1,
        JMP_REG  = 2'd2
    } jmp_e;

    typedef enum logic [1:0] {
        DSEL_RD = 2'd0,
        DSEL_RT = 2'd1,
        DSEL_RA = 2'd2
    } dsel_e;

    typedef enum logic [2:0] {
        IMK_NONE   = 3'd0,
        IMK_SEXT   = 3'd1,
        IMK_ZEXT   = 3'd2,
        IMK_UPPER  = 3'd3,
        IMK_BRANCH = 3'd4,
        IMK_JUMP   = 3'd5
    } imm_kind_e;

    typedef struct packed {
        alu_op_e   alu;
        dsel_e     dsel;
        logic      we_raw;
        logic      src_imm;
        logic      mrd;
        logic      mwr;
        br_e       br;
        jmp_e      jmp;
        logic      link;
        logic      illegal;
        imm_kind_e imk;
    } ctrl_t;

    typedef struct packed {
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] dst;
        dsel_e             dsel;
        logic              we;
        alu_op_e           alu;
        logic              src_imm;
        logic              mrd;
        logic              mwr;
        br_e               br;
        jmp_e              jmp;
        logic              link;
        logic              illegal;
        logic [XLEN-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/mdec_fields.sv
module mdec_fields
    import mdec_pkg::*;
(
    input  logic [XLEN-1:0]   instr_i,
    output logic [OP_W-1:0]   op_o,
    output logic [RIDX_W-1:0] rs_o,
    output logic [RIDX_W-1:0] rt_o,
    output logic [RIDX_W-1:0] rd_o,
    output logic [FN_W-1:0]   fn_o,
    output logic [IMM_W-1:0]  imm16_o,
    output logic [TGT_W-1:0]  tgt_o
);
    localparam int OP_LSB = XLEN - OP_W;
    localparam int RS_LSB = OP_LSB - RIDX_W;
    localparam int RT_LSB = RS_LSB - RIDX_W;
    localparam int RD_LSB = RT_LSB - RIDX_W;

    always_comb begin
        op_o    = instr_i[XLEN-1:OP_LSB];
        rs_o    = instr_i[RS_LSB +: RIDX_W];
        rt_o    = instr_i[RT_LSB +: RIDX_W];
        rd_o    = instr_i[RD_LSB +: RIDX_W];
        fn_o    = instr_i[FN_W-1:0];
        imm16_o = instr_i[IMM_W-1:0];
        tgt_o   = instr_i[TGT_W-1:0];
    end
endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
    import mdec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    input  logic [FN_W-1:0] fn_i,
    output ctrl_t           ctrl_o
);
    always_comb begin
        ctrl_o = '0;
        unique case (op_i)
            OP_RTYPE: begin
                unique case (fn_i)
                    FN_ADD: begin
                        ctrl_o.alu    = ALU_ADD;
                        ctrl_o.we_raw = 1'b1;
                        ctrl_o.dsel   = DSEL_RD;
                    end
                    FN_SUB: begin
                        ctrl_o.alu    = ALU_SUB;
                        ctrl_o.we_raw = 1'b1;
                        ctrl_o.dsel   = DSEL_RD;
                    end
                    FN_SLT: begin
                        ctrl_o.alu    = ALU_SLT;
                        ctrl_o.we_raw = 1'b1;
                        ctrl_o.dsel   = DSEL_RD;
                    end
                    FN_JR: begin
                        ctrl_o.jmp = JMP_REG;
                    end
                    default: ctrl_o.illegal = 1'b1;
                endcase
            end
            OP_LW: begin
                ctrl_o.alu     = ALU_ADD;
                ctrl_o.src_imm = 1'b1;
                ctrl_o.mrd     = 1'b1;
                ctrl_o.we_raw  = 1'b1;
                ctrl_o.dsel    = DSEL_RT;
                ctrl_o.imk     = IMK_SEXT;
            end
            OP_SW: begin
                ctrl_o.alu     = ALU_ADD;
                ctrl_o.src_imm = 1'b1;
                ctrl_o.mwr     = 1'b1;
                ctrl_o.imk     = IMK_SEXT;
            end
            OP_BEQ: begin
                ctrl_o.alu = ALU_SUB;
                ctrl_o.br  = BR_EQ;
                ctrl_o.imk = IMK_BRANCH;
            end
            OP_BNE: begin
                ctrl_o.alu = ALU_SUB;
                ctrl_o.br  = BR_NE;
                ctrl_o.imk = IMK_BRANCH;
            end
            OP_ADDI: begin
                ctrl_o.alu     = ALU_ADD;
                ctrl_o.src_imm = 1'b1;
                ctrl_o.we_raw  = 1'b1;
                ctrl_o.dsel    = DSEL_RT;
                ctrl_o.imk     = IMK_SEXT;
            end
            OP_ORI: begin
                ctrl_o.alu     = ALU_OR;
                ctrl_o.src_imm = 1'b1;
                ctrl_o.we_raw  = 1'b1;
                ctrl_o.dsel    = DSEL_RT;
                ctrl_o.imk     = IMK_ZEXT;
            end
            OP_LUI: begin
                ctrl_o.alu     = ALU_LUI;
                ctrl_o.src_imm = 1'b1;
                ctrl_o.we_raw  = 1'b1;
                ctrl_o.dsel    = DSEL_RT;
                ctrl_o.imk     = IMK_UPPER;
            end
            OP_J: begin
                ctrl_o.jmp = JMP_IMM;
                ctrl_o.imk = IMK_JUMP;
            end
            OP_JAL: begin
                ctrl_o.jmp    = JMP_IMM;
                ctrl_o.imk    = IMK_JUMP;
                ctrl_o.link   = 1'b1;
                ctrl_o.we_raw = 1'b1;
                ctrl_o.dsel   = DSEL_RA;
            end
            default: ctrl_o.illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/mdec_imm.sv
module mdec_imm
    import mdec_pkg::*;
(
    input  logic [IMM_W-1:0] imm16_i,
    input  logic [TGT_W-1:0] tgt_i,
    input  imm_kind_e        kind_i,
    output logic [XLEN-1:0]  imm_o
);
    localparam int EXT_W  = XLEN - IMM_W;
    localparam int BSH    = 2;
    localparam int JPAD_W = XLEN - TGT_W - BSH;

    logic [XLEN-1:0] sext_w;
    logic [XLEN-1:0] zext_w;
    logic [XLEN-1:0] upper_w;
    logic [XLEN-1:0] jump_w;

    genvar gi;
    generate
        for (gi = 0; gi < XLEN; gi++) begin : g_ext
            if (gi < IMM_W) begin : g_low
                assign sext_w[gi] = imm16_i[gi];
                assign zext_w[gi] = imm16_i[gi];
            end else begin : g_high
                assign sext_w[gi] = imm16_i[IMM_W-1];
                assign zext_w[gi] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        upper_w = {imm16_i, {EXT_W{1'b0}}};
        jump_w  = {{JPAD_W{1'b0}}, tgt_i, {BSH{1'b0}}};
        unique case (kind_i)
            IMK_SEXT:   imm_o = sext_w;
            IMK_ZEXT:   imm_o = zext_w;
            IMK_UPPER:  imm_o = upper_w;
            IMK_BRANCH: imm_o = sext_w << BSH;
            IMK_JUMP:   imm_o = jump_w;
            default:    imm_o = '0;
        endcase
    end
endmodule

// File: rtl/mdec_dest.sv
module mdec_dest
    import mdec_pkg::*;
(
    input  dsel_e             dsel_i,
    input  logic              we_raw_i,
    input  logic [RIDX_W-1:0] rd_i,
    input  logic [RIDX_W-1:0] rt_i,
    output logic [RIDX_W-1:0] dst_o,
    output logic              we_o
);
    localparam logic [RIDX_W-1:0] RA_IDX = RIDX_W'(LINK_REG);

    logic [RIDX_W-1:0] idx_w;

    always_comb begin
        unique case (dsel_i)
            DSEL_RT: idx_w = rt_i;
            DSEL_RA: idx_w = RA_IDX;
            default: idx_w = rd_i;
        endcase
        we_o  = we_raw_i && (idx_w != '0);
        dst_o = we_o ? idx_w : '0;
    end
endmodule

// File: rtl/mdec_top.sv
module mdec_top
    import mdec_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [31:0] instr_i,
    output logic [4:0]  rs_o,
    output logic [4:0]  rt_o,
    output logic [4:0]  dst_o,
    output logic [1:0]  dst_sel_o,
    output logic        reg_we_o,
    output logic [2:0]  alu_op_o,
    output logic        alu_src_imm_o,
    output logic        mem_rd_o,
    output logic        mem_wr_o,
    output logic [1:0]  branch_o,
    output logic [1:0]  jump_o,
    output logic        link_o,
    output logic        illegal_o,
    output logic [31:0] imm_o
);
    logic [OP_W-1:0]   op_w;
    logic [RIDX_W-1:0] rs_w;
    logic [RIDX_W-1:0] rt_w;
    logic [RIDX_W-1:0] rd_w;
    logic [FN_W-1:0]   fn_w;
    logic [IMM_W-1:0]  imm16_w;
    logic [TGT_W-1:0]  tgt_w;
    ctrl_t             ctrl_w;
    logic [XLEN-1:0]   imm_w;
    logic [RIDX_W-1:0] dst_w;
    logic              we_w;

    dec_t dec_d;
    dec_t dec_q;

    mdec_fields u_fields (
        .instr_i (instr_i),
        .op_o    (op_w),
        .rs_o    (rs_w),
        .rt_o    (rt_w),
        .rd_o    (rd_w),
        .fn_o    (fn_w),
        .imm16_o (imm16_w),
        .tgt_o   (tgt_w)
    );

    mdec_ctrl u_ctrl (
        .op_i   (op_w),
        .fn_i   (fn_w),
        .ctrl_o (ctrl_w)
    );

    mdec_imm u_imm (
        .imm16_i (imm16_w),
        .tgt_i   (tgt_w),
        .kind_i  (ctrl_w.imk),
        .imm_o   (imm_w)
    );

    mdec_dest u_dest (
        .dsel_i   (ctrl_w.dsel),
        .we_raw_i (ctrl_w.we_raw),
        .rd_i     (rd_w),
        .rt_i     (rt_w),
        .dst_o    (dst_w),
        .we_o     (we_w)
    );

    always_comb begin
        dec_d         = '0;
        dec_d.rs      = rs_w;
        dec_d.rt      = rt_w;
        dec_d.dst     = dst_w;
        dec_d.dsel    = ctrl_w.dsel;
        dec_d.we      = we_w;
        dec_d.alu     = ctrl_w.alu;
        dec_d.src_imm = ctrl_w.src_imm;
        dec_d.mrd     = ctrl_w.mrd;
        dec_d.mwr     = ctrl_w.mwr;
        dec_d.br      = ctrl_w.br;
        dec_d.jmp     = ctrl_w.jmp;
        dec_d.link    = ctrl_w.link;
        dec_d.illegal = ctrl_w.illegal;
        dec_d.imm     = imm_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    always_comb begin
        rs_o          = dec_q.rs;
        rt_o          = dec_q.rt;
        dst_o         = dec_q.dst;
        dst_sel_o     = dec_q.dsel;
        reg_we_o      = dec_q.we;
        alu_op_o      = dec_q.alu;
        alu_src_imm_o = dec_q.src_imm;
        mem_rd_o      = dec_q.mrd;
        mem_wr_o      = dec_q.mwr;
        branch_o      = dec_q.br;
        jump_o        = dec_q.jmp;
        link_o        = dec_q.link;
        illegal_o     = dec_q.illegal;
        imm_o         = dec_q.imm;
    end
endmodule

// File: rtl/mdec_chk.sv
module mdec_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [31:0] instr_i,
    input logic [4:0]  rs_o,
    input logic [4:0]  dst_o,
    input logic        reg_we_o,
    input logic [2:0]  alu_op_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [1:0]  branch_o,
    input logic [1:0]  jump_o,
    input logic        link_o,
    input logic        illegal_o,
    input logic [31:0] imm_o
);
    assert_rs_follows_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> rs_o == $past(instr_i[25:21]));

    assert_mem_exclusive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(mem_rd_o && mem_wr_o));

    assert_lui_low_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_i[31:26] == 6'b001111 |=> imm_o[15:0] == 16'h0 && alu_op_o == 3'd4);

    assert_branch_nowrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        branch_o != 2'd0 |-> !reg_we_o && !mem_wr_o);

    assert_jal_link_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        instr_i[31:26] == 6'b000011 |=> reg_we_o && dst_o == 5'd31 && link_o && jump_o == 2'd1);

    assert_illegal_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> !reg_we_o && !mem_wr_o && !mem_rd_o && branch_o == 2'd0 && jump_o == 2'd0);

    assert_no_zero_dest_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        reg_we_o |-> dst_o != 5'd0);
endmodule

bind mdec_top mdec_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .instr_i   (instr_i),
    .rs_o      (rs_o),
    .dst_o     (dst_o),
    .reg_we_o  (reg_we_o),
    .alu_op_o  (alu_op_o),
    .mem_rd_o  (mem_rd_o),
    .mem_wr_o  (mem_wr_o),
    .branch_o  (branch_o),
    .jump_o    (jump_o),
    .link_o    (link_o),
    .illegal_o (illegal_o),
    .imm_o     (imm_o)
);

// File: tb/tb_mdec_top.sv
module tb_mdec_top;
    localparam int CLK_P = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [31:0] instr_i = '0;
    logic [4:0]  rs_o, rt_o, dst_o;
    logic [1:0]  dst_sel_o, branch_o, jump_o;
    logic        reg_we_o, alu_src_imm_o, mem_rd_o, mem_wr_o, link_o, illegal_o;
    logic [2:0]  alu_op_o;
    logic [31:0] imm_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [61:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    mdec_top dut (
        .clk_i(clk_i), .rst_ni(rst_ni), .instr_i(instr_i),
        .rs_o(rs_o), .rt_o(rt_o), .dst_o(dst_o), .dst_sel_o(dst_sel_o),
        .reg_we_o(reg_we_o), .alu_op_o(alu_op_o), .alu_src_imm_o(alu_src_imm_o),
        .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .branch_o(branch_o),
        .jump_o(jump_o), .link_o(link_o), .illegal_o(illegal_o), .imm_o(imm_o)
    );

    always #(CLK_P/2) clk_i = ~clk_i;

    function automatic logic [61:0] actual();
        return {rs_o, rt_o, dst_o, dst_sel_o, reg_we_o, alu_op_o, alu_src_imm_o,
                mem_rd_o, mem_wr_o, branch_o, jump_o, link_o, illegal_o, imm_o};
    endfunction

    // expected result built from the requirement text
    function automatic logic [61:0] model(input logic [31:0] ins);
        logic [5:0]  op  = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [4:0]  rs  = ins[25:21];
        logic [4:0]  rt  = ins[20:16];
        logic [4:0]  rd  = ins[15:11];
        logic [15:0] k   = ins[15:0];
        logic [31:0] sx  = {{16{k[15]}}, k};
        logic [1:0]  sel = 0, br = 0, jp = 0;
        logic [2:0]  alu = 0;
        logic        wr = 0, si = 0, mr = 0, mw = 0, lk = 0, il = 0, we;
        logic [4:0]  widx = 0, dst;
        logic [31:0] imm = 0;
        case (op)
            6'b000000: case (fn)
                6'b100000: begin alu = 0; wr = 1; widx = rd; end
                6'b100010: begin alu = 1; wr = 1; widx = rd; end
                6'b101010: begin alu = 2; wr = 1; widx = rd; end
                6'b001000: jp = 2;
                default:   il = 1;
            endcase
            6'b100011: begin si = 1; mr = 1; wr = 1; widx = rt; sel = 1; imm = sx; end
            6'b101011: begin si = 1; mw = 1; imm = sx; end
            6'b000100: begin alu = 1; br = 1; imm = sx << 2; end
            6'b000101: begin alu = 1; br = 2; imm = sx << 2; end
            6'b001000: begin si = 1; wr = 1; widx = rt; sel = 1; imm = sx; end
            6'b001101: begin alu = 3; si = 1; wr = 1; widx = rt; sel = 1; imm = {16'h0, k}; end
            6'b001111: begin alu = 4; si = 1; wr = 1; widx = rt; sel = 1; imm = {k, 16'h0}; end
            6'b000010: begin jp = 1; imm = {4'h0, ins[25:0], 2'b00}; end
            6'b000011: begin jp = 1; lk = 1; wr = 1; widx = 5'd31; sel = 2;
                             imm = {4'h0, ins[25:0], 2'b00}; end
            default:   il = 1;
        endcase
        we  = wr && (widx != 0);
        dst = we ? widx : 5'd0;
        return {rs, rt, dst, sel, we, alu, si, mr, mw, br, jp, lk, il, imm};
    endfunction

    function automatic logic [31:0] rtype(input logic [4:0] s, t, d, input logic [5:0] f);
        return {6'b000000, s, t, d, 5'd0, f};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] o, input logic [4:0] s, t,
                                          input logic [15:0] k);
        return {o, s, t, k};
    endfunction

    task automatic check(input string tag, input logic [61:0] act, input logic [61:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] ins, input string tag);
        item_t it;
        @(negedge clk_i);
        instr_i = ins;
        it.exp  = model(ins);
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    // monitor: result due one edge after the instruction is applied (R12)
    always @(posedge clk_i) begin
        #(CLK_P/4);
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, actual(), it.exp);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P*100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        instr_i = 32'h8C22_0004;
        repeat (3) @(negedge clk_i);
        check("R12 reset clears outputs", actual(), 62'h0);
        rst_ni = 1'b1;

        drive(rtype(5'd1, 5'd2, 5'd3, 6'b100000), "R2 add");
        drive(rtype(5'd4, 5'd5, 5'd6, 6'b100010), "R2 sub");
        drive(rtype(5'd7, 5'd8, 5'd9, 6'b101010), "R2 slt");
        drive(rtype(5'd1, 5'd2, 5'd0, 6'b100000), "R11 add to r0");
        drive(rtype(5'd31, 5'd0, 5'd0, 6'b001000), "R9 jr");
        drive(rtype(5'd1, 5'd2, 5'd3, 6'b100001), "R10 bad funct");
        drive(itype(6'b100011, 5'd19, 5'd8, 16'hFFF0), "R3 lw neg");
        drive(itype(6'b101011, 5'd19, 5'd8, 16'h0030), "R3 sw");
        drive(itype(6'b001000, 5'd29, 5'd29, 16'hFFFC), "R4 addi neg");
        drive(itype(6'b001000, 5'd3, 5'd0, 16'h0005), "R11 addi to r0");
        drive(itype(6'b001101, 5'd16, 5'd16, 16'h8001), "R5 ori zext");
        drive(itype(6'b001111, 5'd0, 5'd16, 16'hABCD), "R6 lui");
        drive(itype(6'b000100, 5'd17, 5'd18, 16'hFFFF), "R7 beq back");
        drive(itype(6'b000101, 5'd19, 5'd20, 16'h0019), "R7 bne fwd");
        drive({6'b000010, 26'h00009C4}, "R8 j");
        drive({6'b000011, 26'h3FFFFFF}, "R8 jal");
        drive(itype(6'b111111, 5'd1, 5'd2, 16'h1234), "R10 bad opcode");
        drive(itype(6'b000001, 5'd3, 5'd4, 16'h0001), "R10 opcode 000001");
        drive(32'hFFFF_FFFF, "R1 all-ones fields");
        drive(itype(6'b100011, 5'd0, 5'd0, 16'h7FFF), "R11 lw to r0");
        repeat (3) @(negedge clk_i);
        finish_run();
    end
endmodule